// File: doc/BRIEF.md
# System Clock Divider Controller

This block turns a 3-bit divide request from software into a system clock enable. The enable runs off a 64 MHz reference and yields 64, 32, 16, 8, 4, 2 or 1 MHz. Request code N selects divide-by-2^N. The output is a one-cycle enable strobe on the reference clock, not a gated clock.

Hardware overrides filter each request before it is stored:
- While the radio is enabled, the slow codes are capped at 16 MHz.
- A 64 MHz request made while the external oscillator is selected forces the system clock back onto the internal reference.
- If that reference is also stopped, the same request asks for the reference to be restarted.

A stored request does not take effect at once. It waits for a free-running 7-bit counter to wrap to zero. A status output shows the ratio actually in force, so software can confirm that the switch has happened.

Top module: `sysdiv_top`

## Requirements
- R1: Synchronous active-low reset sets the stored request and the status to 001 (32 MHz) and clears the counter, the force-internal flag and the restart request.
- R2: With status code N (0 to 6), the strobe is high for one reference cycle every 2^N cycles: 000 gives 64 MHz, 001 gives 32, 010 gives 16, 011 gives 8, 100 gives 4, 101 gives 2 and 110 gives 1 MHz.
- R3: The status changes only in the cycle where the 7-bit counter reaches zero. It then takes the stored request, so it reflects a write no more than 128 cycles later.
- R4: The strobe is always high in the cycle where the counter is zero, so every ratio stays phase-aligned across a switch.
- R5: While radioEn is high, a write of 011, 100, 101 or 110 is stored as 010. Writes of 000, 001 and 010 are stored unchanged.
- R6: A write of 111 is ignored. The stored request, the status and the force-internal flag keep their values.
- R7: A write of 000 while extOscSel is 1 sets forceIntRef in the next cycle. The flag holds until the next accepted write, which clears it unless that write repeats the same case.
- R8: refRestartReq pulses high for exactly one cycle, the cycle after a write of 000 made while extOscSel and stopRef are both 1. It is low at all other times.
- R9: A write of 000 while extOscSel is 0 leaves forceIntRef low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 64 MHz reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Write strobe for the divide request |
| wrDiv | input | 3 | Requested divide code |
| radioEn | input | 1 | Radio active; caps the slow codes at 16 MHz |
| extOscSel | input | 1 | System clock currently taken from the external oscillator |
| stopRef | input | 1 | Internal reference is stopped |
| sysClkEn | output | 1 | System clock enable strobe |
| divStatus | output | 3 | Divide code actually in force |
| forceIntRef | output | 1 | Move the system clock back to the internal reference |
| refRestartReq | output | 1 | One-cycle request to restart the internal reference |

## Verification
The stored request, forceIntRef and refRestartReq are each due one clock after the write edge. The bench samples them at the falling edge that follows the write. The status is due at the first cycle in which the counter is zero. The bench keeps its own cycle count since reset, checks that the old status holds until that count reaches zero, and then expects the new code there. Once the status is settled, the strobe is compared cycle by cycle over a full 128-cycle counter period against the arithmetic pattern for that code.

// File: rtl/sysdiv_pkg.sv
package sysdiv_pkg;
  localparam int DIV_W = 3;
  typedef logic [DIV_W-1:0] divCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     applyNow;
    divCode_t nextDiv;
  } divCtl_t;
endpackage

// File: rtl/sysdiv_ctrl.sv
module sysdiv_ctrl
  import sysdiv_pkg::*;
#(
  parameter divCode_t RESET_DIV = 3'd1,
  parameter divCode_t RADIO_CAP = 3'd2,
  parameter divCode_t RADIO_LO  = 3'd3,
  parameter divCode_t RADIO_HI  = 3'd6,
  parameter divCode_t UNUSED    = 3'd7
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrEn,
  input  divCode_t wrDiv,
  input  logic     radioEn,
  input  logic     extOscSel,
  input  logic     stopRef,
  input  logic     cntLast,
  output divCtl_t  ctl,
  output logic     forceIntRef,
  output logic     refRestartReq
);
  localparam divCode_t FAST_DIV = '0;

  divCode_t reqDiv;
  divCode_t filtDiv;
  logic     accept;
  logic     fastOnExt;

  always_comb begin
    accept    = wrEn && (wrDiv != UNUSED);
    filtDiv   = (radioEn && wrDiv >= RADIO_LO && wrDiv <= RADIO_HI) ? RADIO_CAP : wrDiv;
    fastOnExt = accept && (filtDiv == FAST_DIV) && extOscSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqDiv        <= RESET_DIV;
      forceIntRef   <= 1'b0;
      refRestartReq <= 1'b0;
    end else begin
      refRestartReq <= fastOnExt && stopRef;
      if (accept) begin
        reqDiv      <= filtDiv;
        forceIntRef <= fastOnExt;
      end
    end
  end

  assign ctl.applyNow = cntLast;
  assign ctl.nextDiv  = reqDiv;

  a_r5_radio_cap: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && radioEn && wrDiv >= RADIO_LO && wrDiv <= RADIO_HI) |=> (reqDiv == RADIO_CAP));
  a_r6_unused_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrDiv == UNUSED) |=> ($stable(reqDiv) && $stable(forceIntRef)));
  a_r6_never_stored: assert property (@(posedge clk) disable iff (!rstN)
    reqDiv != UNUSED);
  a_r8_restart_pulse: assert property (@(posedge clk) disable iff (!rstN)
    refRestartReq |-> (forceIntRef && reqDiv == FAST_DIV));
  a_r9_no_force_internal: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrDiv == FAST_DIV && !extOscSel) |=> !forceIntRef);
endmodule

// File: rtl/sysdiv_dpath.sv
module sysdiv_dpath
  import sysdiv_pkg::*;
#(
  parameter int       CNT_W     = 7,
  parameter divCode_t RESET_DIV = 3'd1
) (
  input  logic     clk,
  input  logic     rstN,
  input  divCtl_t  ctl,
  output logic     cntLast,
  output logic     sysClkEn,
  output divCode_t divStatus
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phaseMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      divStatus <= RESET_DIV;
    end else begin
      cnt <= cnt + CNT_ONE;
      if (ctl.applyNow) divStatus <= ctl.nextDiv;
    end
  end

  always_comb begin
    cntLast   = (cnt == CNT_MAX);
    phaseMask = (CNT_ONE << divStatus) - CNT_ONE;
    sysClkEn  = ((cnt & phaseMask) == '0);
  end

  a_r3_switch_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divStatus) |-> (cnt == '0));
  a_r4_strobe_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == '0) |-> sysClkEn);
  a_r2_back_to_back_only_fast: assert property (@(posedge clk) disable iff (!rstN)
    (sysClkEn && $past(sysClkEn) && cnt != '0) |-> (divStatus == '0));
endmodule

// File: rtl/sysdiv_top.sv
module sysdiv_top
  import sysdiv_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrDiv,
  input  logic       radioEn,
  input  logic       extOscSel,
  input  logic       stopRef,
  output logic       sysClkEn,
  output logic [2:0] divStatus,
  output logic       forceIntRef,
  output logic       refRestartReq
);
  divCtl_t ctl;
  logic    cntLast;

  sysdiv_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrDiv(wrDiv),
    .radioEn(radioEn), .extOscSel(extOscSel), .stopRef(stopRef),
    .cntLast(cntLast), .ctl(ctl),
    .forceIntRef(forceIntRef), .refRestartReq(refRestartReq)
  );

  sysdiv_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cntLast(cntLast), .sysClkEn(sysClkEn), .divStatus(divStatus)
  );
endmodule

// File: tb/sysdiv_top_tb_top.sv
`timescale 1ns/1ps
module sysdiv_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrDiv = 3'd0;
  logic radioEn = 1'b0, extOscSel = 1'b0, stopRef = 1'b0;
  logic sysClkEn, forceIntRef, refRestartReq;
  logic [2:0] divStatus;

  int nChecks = 0;
  int nFails = 0;
  int benchCnt = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  sysdiv_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrDiv(wrDiv),
    .radioEn(radioEn), .extOscSel(extOscSel), .stopRef(stopRef),
    .sysClkEn(sysClkEn), .divStatus(divStatus),
    .forceIntRef(forceIntRef), .refRestartReq(refRestartReq)
  );

  // cycles since reset release, modulo the 128-cycle counter period
  always @(posedge clk) benchCnt <= rstN ? ((benchCnt + 1) % 128) : 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cnt %0d)", req, act, exp, benchCnt);
    end
  endtask

  // R2/R4: one full period of strobe pattern for code n, starting at cnt 0
  task automatic check_strobes(input int n);
    for (int k = 0; k < 128; k++) begin
      check(n == 2 ? "R2 strobe" : "R2/R4 strobe", int'(sysClkEn),
            int'((benchCnt % (1 << n)) == 0));
      @(negedge clk);
    end
  endtask

  // R3: status holds the old code until the counter reaches zero
  task automatic wait_switch(input int oldS, input int newS);
    int lat = 0;
    while (benchCnt != 0 && lat <= 128) begin
      check("R3 status held", int'(divStatus), oldS);
      @(negedge clk);
      lat++;
    end
    check("R3 latency within 128", int'(lat <= 128), 1);
    check("R3 status at wrap", int'(divStatus), newS);
  endtask

  task automatic write_code(input int code);
    wrEn = 1'b1;
    wrDiv = 3'(code);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    int st, frc, expS, expF, expR;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state (cnt 0 right after release)
    check("R1 status", int'(divStatus), 1);
    check("R1 force", int'(forceIntRef), 0);
    check("R1 restart", int'(refRestartReq), 0);
    check("R1 strobe at zero", int'(sysClkEn), 1);
    check_strobes(1);
    st = 1;
    frc = 0;
    for (int r = 0; r < 2; r++)
      for (int e = 0; e < 2; e++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 8; c++) begin
            radioEn = r[0];
            extOscSel = e[0];
            stopRef = s[0];
            // land writes on different counter phases
            repeat ((c * 37 + r * 11 + s * 5) % 128) @(negedge clk);
            write_code(c);
            if (c == 7) begin
              expS = st;
              expF = frc;
            end else begin
              expS = (r == 1 && c >= 3 && c <= 6) ? 2 : c;
              expF = (c == 0 && e == 1) ? 1 : 0;
            end
            expR = (c == 0 && e == 1 && s == 1) ? 1 : 0;
            check(c == 0 ? (e == 1 ? "R7 force" : "R9 force") : "R6 force",
                  int'(forceIntRef), expF);
            check("R8 restart pulse", int'(refRestartReq), expR);
            @(negedge clk);
            check("R8 restart single", int'(refRestartReq), 0);
            wait_switch(st, expS);
            check(c == 7 ? "R6 ignored" : (r == 1 ? "R5 cap" : "R3 status"),
                  int'(divStatus), expS);
            check_strobes(expS);
            check("R7 force held", int'(forceIntRef), expF);
            st = expS;
            frc = expF;
          end
    // R1 reset again from a non-default state
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1 status after reset", int'(divStatus), 1);
    check("R1 force after reset", int'(forceIntRef), 0);
    done = 1'b1;
  end

  initial begin
    int waited = 0;
    while (!done && waited < 190000) begin
      @(posedge clk);
      waited++;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule